// File: doc/BRIEF.md
# Fuse Array Word Read Sequencer

This block reads a run of consecutive 32-bit words out of a one-time-programmable fuse array. A client asks for a run once, with a single-cycle request that carries a start position and a length. The start and length are given either as a word index and word count or as a byte offset and byte size, and a mode input selects which. The block first checks the request against the array size. It then wakes the fuse macro and reads the words one by one, returning each on a valid-qualified output. Last, it puts the macro back to sleep and signals completion.

The fuse macro has no clock of its own. It is clocked by a pin that the sequencer drives high for a long read-access interval and then low for a recovery interval. The macro's standby, repair-enable and chip-enable inputs must be raised and lowered in a fixed order around the reads. All intervals are cycle counts derived from a clock-frequency parameter. The low 256 words carry no access restriction in this block; any policy on them belongs to the client.

Top module: `otp_read_seq`

## Requirements
- R1: With `req_bytes_i`=0, the start and count are a word index and a word count. With `req_bytes_i`=1, they are a byte offset and a byte size, and the first word index is offset/4 and the word count is size/4.
- R2: In byte mode, a request whose offset or size has either of bits [1:0] nonzero is rejected.
- R3: A request whose start or count has bit 31 set (a negative value) is rejected.
- R4: A request is rejected if its first word index is at or above FUSE_WORDS (4096), or if index plus count exceeds FUSE_WORDS.
- R5: A rejected request raises `err_o` and `done_o` together for exactly one cycle, in the cycle after the request. `busy_o` and every macro pin stay low.
- R6: For an accepted request, `fuse_stby_n_o` rises first. `fuse_trim_o` rises one cycle later and `fuse_ce_o` one cycle after that, all before the first macro clock pulse.
- R7: For each word, the address is held stable while `fuse_clk_o` is high. The clock stays high for exactly CLK_MHZ*T_ACCESS_US cycles and then low for at least CLK_MHZ*T_LOW_US cycles. The clock only goes high while all three power pins are high.
- R8: The word sampled from `fuse_dout_i` at the end of each low interval is presented on `word_data_o`, together with its index on `word_idx_o` and a one-cycle `word_valid_o` pulse. Words come in ascending index order, one per requested word.
- R9: After the last word, `fuse_ce_o` falls first, then `fuse_trim_o` one cycle later, then `fuse_stby_n_o` one cycle after that. `done_o` pulses one cycle later with `err_o` low and `busy_o` low.
- R10: `busy_o` is high from the cycle after an accepted request until the cycle `done_o` pulses. Requests made while it is high are ignored.
- R11: A valid request with a count of zero performs the full power-up and power-down orderings, returns no word, and ends with `done_o` and no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Single-cycle read request |
| req_bytes_i | input | 1 | 1: start/count in bytes, 0: in words |
| req_start_i | input | REQ_W | Start index or byte offset (two's complement) |
| req_count_i | input | REQ_W | Word count or byte size (two's complement) |
| busy_o | output | 1 | Read run in progress |
| done_o | output | 1 | One-cycle end-of-request pulse |
| err_o | output | 1 | One-cycle rejection pulse, with done_o |
| word_valid_o | output | 1 | One-cycle pulse qualifying a returned word |
| word_idx_o | output | ADDR_W | Index of the returned word |
| word_data_o | output | DATA_W | Returned word |
| fuse_stby_n_o | output | 1 | Macro deep-standby control, active low |
| fuse_trim_o | output | 1 | Macro repair-enable input |
| fuse_ce_o | output | 1 | Macro chip enable |
| fuse_addr_o | output | ADDR_W | Macro word address |
| fuse_clk_o | output | 1 | Macro read clock |
| fuse_dout_i | input | DATA_W | Macro data out |

## Verification
The hardest case to reach from the ports is a request that arrives while a run is already under way. The bench drives such a request in the middle of the power-up and word phases. It then checks that the words returned still belong to the first run and that only one done pulse appears. The array-end boundaries are also hard to hit with random values, so directed requests sit exactly on them: last word, one past the end, and an index plus count that overflows by one. The fuse stub drives junk data while the macro clock is high and only shows real data after the falling edge. A controller that samples too early therefore returns wrong words.

// File: rtl/otp_rd_pkg.sv
package otp_rd_pkg;
  typedef enum logic [3:0] {
    S_IDLE,
    S_UP_STBY,
    S_UP_TRIM,
    S_UP_CE,
    S_ADDR,
    S_CLK_HI,
    S_CLK_LO,
    S_DN_CE,
    S_DN_TRIM,
    S_DN_STBY
  } otp_rd_state_e;

  typedef struct packed {
    logic stby_n;
    logic trim;
    logic ce;
    logic pclk;
  } otp_pins_t;
endpackage

// File: rtl/otp_req_check.sv
module otp_req_check #(
  parameter int REQ_W      = 32,
  parameter int FUSE_WORDS = 4096,
  parameter int ADDR_W     = 12,
  parameter int CNT_W      = 13
) (
  input  logic              byte_mode_i,
  input  logic [REQ_W-1:0]  start_i,
  input  logic [REQ_W-1:0]  count_i,
  output logic              ok_o,
  output logic [ADDR_W-1:0] idx_o,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [REQ_W-1:0] idx_w;
  logic [REQ_W-1:0] cnt_w;
  logic [REQ_W:0]   end_w;
  logic negative, misalign, past_end, overrun;

  always_comb begin
    negative = start_i[REQ_W-1] | count_i[REQ_W-1];
    misalign = byte_mode_i & ((start_i[1:0] != 2'b00) | (count_i[1:0] != 2'b00));
    idx_w    = byte_mode_i ? {2'b00, start_i[REQ_W-1:2]} : start_i;
    cnt_w    = byte_mode_i ? {2'b00, count_i[REQ_W-1:2]} : count_i;
    end_w    = {1'b0, idx_w} + {1'b0, cnt_w};
    past_end = idx_w >= REQ_W'(FUSE_WORDS);
    overrun  = end_w > (REQ_W+1)'(FUSE_WORDS);
    ok_o     = !negative && !misalign && !past_end && !overrun;
    idx_o    = idx_w[ADDR_W-1:0];
    cnt_o    = cnt_w[CNT_W-1:0];
  end
endmodule

// File: rtl/otp_phase_timer.sv
module otp_phase_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [TMR_W-1:0] load_val_i,
  output logic             expired_o
);
  logic [TMR_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : cnt_q - TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

  // R7: a running interval counts down by exactly one each cycle
  p_tmr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cnt_q) != '0 && !$past(load_i)) |-> cnt_q == $past(cnt_q) - TMR_W'(1));
endmodule

// File: rtl/otp_word_cursor.sv
module otp_word_cursor #(
  parameter int ADDR_W = 12,
  parameter int CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] idx_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              last_o,
  output logic              empty_o
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  left_q, left_d;
  logic              upd_en;

  always_comb begin
    upd_en = load_i || step_i;
    addr_d = load_i ? idx_i : addr_q + ADDR_W'(1);
    left_d = load_i ? cnt_i : left_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      left_q <= '0;
    end else if (upd_en) begin
      addr_q <= addr_d;
      left_q <= left_d;
    end
  end

  assign addr_o  = addr_q;
  assign last_o  = (left_q == CNT_W'(1));
  assign empty_o = (left_q == '0);

  // R8: never step past the requested count
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> !empty_o);
  // R8: each step moves to the next ascending index
  p_ascend_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(step_i) && !$past(load_i) |-> addr_q == $past(addr_q) + ADDR_W'(1));
endmodule

// File: rtl/otp_read_seq.sv
module otp_read_seq
  import otp_rd_pkg::*;
#(
  parameter int REQ_W       = 32,
  parameter int DATA_W      = 32,
  parameter int FUSE_WORDS  = 4096,
  parameter int CLK_MHZ     = 250,
  parameter int T_ACCESS_US = 40,
  parameter int T_LOW_US    = 10
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              req_i,
  input  logic                              req_bytes_i,
  input  logic [REQ_W-1:0]                  req_start_i,
  input  logic [REQ_W-1:0]                  req_count_i,
  output logic                              busy_o,
  output logic                              done_o,
  output logic                              err_o,
  output logic                              word_valid_o,
  output logic [$clog2(FUSE_WORDS)-1:0]     word_idx_o,
  output logic [DATA_W-1:0]                 word_data_o,
  output logic                              fuse_stby_n_o,
  output logic                              fuse_trim_o,
  output logic                              fuse_ce_o,
  output logic [$clog2(FUSE_WORDS)-1:0]     fuse_addr_o,
  output logic                              fuse_clk_o,
  input  logic [DATA_W-1:0]                 fuse_dout_i
);
  localparam int ADDR_W  = $clog2(FUSE_WORDS);
  localparam int CNT_W   = $clog2(FUSE_WORDS + 1);
  localparam int HI_CYC  = (CLK_MHZ * T_ACCESS_US < 1) ? 1 : CLK_MHZ * T_ACCESS_US;
  localparam int LO_CYC  = (CLK_MHZ * T_LOW_US < 1) ? 1 : CLK_MHZ * T_LOW_US;
  localparam int MAX_CYC = (HI_CYC > LO_CYC) ? HI_CYC : LO_CYC;
  localparam int TMR_W   = $clog2(MAX_CYC + 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  otp_rd_state_e state_q, state_d;
  logic              chk_ok;
  logic [ADDR_W-1:0] chk_idx;
  logic [CNT_W-1:0]  chk_cnt;
  logic              tmr_load, tmr_exp;
  logic [TMR_W-1:0]  tmr_val;
  logic              cur_load, cur_step, cur_last, cur_empty;
  logic [ADDR_W-1:0] cur_addr;
  logic              rej, fin, capture;
  otp_pins_t         pins;

  otp_req_check #(
    .REQ_W(REQ_W), .FUSE_WORDS(FUSE_WORDS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_check (
    .byte_mode_i(req_bytes_i), .start_i(req_start_i), .count_i(req_count_i),
    .ok_o(chk_ok), .idx_o(chk_idx), .cnt_o(chk_cnt)
  );

  otp_phase_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n_s), .load_i(tmr_load), .load_val_i(tmr_val),
    .expired_o(tmr_exp)
  );

  otp_word_cursor #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cursor (
    .clk(clk), .rst_n(rst_n_s), .load_i(cur_load), .idx_i(chk_idx),
    .cnt_i(chk_cnt), .step_i(cur_step), .addr_o(cur_addr),
    .last_o(cur_last), .empty_o(cur_empty)
  );

  // next-state logic
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cur_load = 1'b0;
    cur_step = 1'b0;
    rej      = 1'b0;
    fin      = 1'b0;
    capture  = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (req_i) begin
          if (chk_ok) begin
            state_d  = S_UP_STBY;
            cur_load = 1'b1;
          end else begin
            rej = 1'b1;
          end
        end
      end
      S_UP_STBY: state_d = S_UP_TRIM;
      S_UP_TRIM: state_d = S_UP_CE;
      S_UP_CE:   state_d = cur_empty ? S_DN_CE : S_ADDR;
      S_ADDR: begin
        state_d  = S_CLK_HI;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(HI_CYC - 1);
      end
      S_CLK_HI: begin
        if (tmr_exp) begin
          state_d  = S_CLK_LO;
          tmr_load = 1'b1;
          tmr_val  = TMR_W'(LO_CYC - 1);
        end
      end
      S_CLK_LO: begin
        if (tmr_exp) begin
          capture  = 1'b1;
          cur_step = 1'b1;
          state_d  = cur_last ? S_DN_CE : S_ADDR;
        end
      end
      S_DN_CE:   state_d = S_DN_TRIM;
      S_DN_TRIM: state_d = S_DN_STBY;
      S_DN_STBY: begin
        state_d = S_IDLE;
        fin     = 1'b1;
      end
      default:   state_d = S_IDLE;
    endcase
  end

  // state and result registers
  logic              done_q, err_q, valid_q;
  logic [ADDR_W-1:0] widx_q;
  logic [DATA_W-1:0] wdata_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= S_IDLE;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= fin | rej;
      err_q   <= rej;
      valid_q <= capture;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      widx_q  <= '0;
      wdata_q <= '0;
    end else if (capture) begin
      widx_q  <= cur_addr;
      wdata_q <= fuse_dout_i;
    end
  end

  // macro pin decode
  always_comb begin
    pins.stby_n = (state_q != S_IDLE) && (state_q != S_DN_STBY);
    pins.trim   = pins.stby_n && (state_q != S_UP_STBY) && (state_q != S_DN_TRIM);
    pins.ce     = (state_q == S_UP_CE) || (state_q == S_ADDR) ||
                  (state_q == S_CLK_HI) || (state_q == S_CLK_LO);
    pins.pclk   = (state_q == S_CLK_HI);
  end

  assign fuse_stby_n_o = pins.stby_n;
  assign fuse_trim_o   = pins.trim;
  assign fuse_ce_o     = pins.ce;
  assign fuse_clk_o    = pins.pclk;
  assign fuse_addr_o   = ((state_q == S_ADDR) || (state_q == S_CLK_HI) ||
                          (state_q == S_CLK_LO)) ? cur_addr : '0;
  assign busy_o        = (state_q != S_IDLE);
  assign done_o        = done_q;
  assign err_o         = err_q;
  assign word_valid_o  = valid_q;
  assign word_idx_o    = widx_q;
  assign word_data_o   = wdata_q;

  // checker-only count of the current clock-high run
  logic [TMR_W:0] hi_run_q;
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)        hi_run_q <= '0;
    else if (fuse_clk_o) hi_run_q <= hi_run_q + (TMR_W+1)'(1);
    else                 hi_run_q <= '0;
  end

  p_up_trim_after_stby_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(fuse_trim_o) |-> fuse_stby_n_o && $past(fuse_stby_n_o));
  p_up_ce_after_trim_r6: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(fuse_ce_o) |-> fuse_trim_o && $past(fuse_trim_o));
  p_clk_powered_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    fuse_clk_o |-> fuse_ce_o && fuse_trim_o && fuse_stby_n_o);
  p_addr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    fuse_clk_o |-> $stable(fuse_addr_o));
  p_hi_width_r7: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(fuse_clk_o) |-> hi_run_q == (TMR_W+1)'(HI_CYC));
  p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n_s)
    word_valid_o |=> !word_valid_o);
  p_dn_trim_after_ce_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(fuse_trim_o) |-> !fuse_ce_o && !$past(fuse_ce_o));
  p_dn_stby_after_trim_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    $fell(fuse_stby_n_o) |-> !$past(fuse_trim_o));
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |-> !busy_o);
  p_reject_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    err_o |-> done_o && !busy_o && !fuse_stby_n_o);
  p_err_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n_s)
    err_o |=> !err_o);
endmodule

// File: tb/otp_read_seq_tb_top.sv
package otp_tb_pkg;
  function automatic logic [31:0] fuse_val(input int idx);
    logic [31:0] v;
    v = 32'(idx) * 32'h9E37_79B1;
    return v ^ 32'h5A5A_C3C3;
  endfunction
endpackage

module otp_fuse_stub #(
  parameter int ADDR_W = 12
) (
  input  logic              stby_n,
  input  logic              trim,
  input  logic              ce,
  input  logic              pclk,
  input  logic [ADDR_W-1:0] addr,
  output logic [31:0]       dout
);
  logic [ADDR_W-1:0] lat;
  initial begin
    dout = 32'h0;
    lat  = '0;
  end
  always @(posedge pclk) begin
    lat  <= addr;
    dout <= 32'hDEAD_BEEF;
  end
  always @(negedge pclk)
    dout <= (stby_n && trim && ce) ? otp_tb_pkg::fuse_val(int'(lat)) : 32'hBAD0_0BAD;
endmodule

module otp_read_seq_tb_top;
  localparam int FW = 4096;
  localparam int AW = 12;
  localparam int HI = 40;
  localparam int LO = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_i = 1'b0, req_bytes_i = 1'b0;
  logic [31:0] req_start_i = '0, req_count_i = '0;
  logic busy_o, done_o, err_o, word_valid_o;
  logic [AW-1:0] word_idx_o, fuse_addr_o;
  logic [31:0] word_data_o, fuse_dout;
  logic stby_n, trim, ce, pclk;

  always #2 clk = ~clk;

  otp_read_seq #(.FUSE_WORDS(FW), .CLK_MHZ(1), .T_ACCESS_US(40), .T_LOW_US(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .req_bytes_i(req_bytes_i),
    .req_start_i(req_start_i), .req_count_i(req_count_i), .busy_o(busy_o),
    .done_o(done_o), .err_o(err_o), .word_valid_o(word_valid_o),
    .word_idx_o(word_idx_o), .word_data_o(word_data_o),
    .fuse_stby_n_o(stby_n), .fuse_trim_o(trim), .fuse_ce_o(ce),
    .fuse_addr_o(fuse_addr_o), .fuse_clk_o(pclk), .fuse_dout_i(fuse_dout)
  );

  otp_fuse_stub #(.ADDR_W(AW)) u_stub (
    .stby_n(stby_n), .trim(trim), .ce(ce), .pclk(pclk), .addr(fuse_addr_o),
    .dout(fuse_dout)
  );

  int total = 0;
  int failed = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic bit model(input bit bm, input longint s, input longint c,
                               output longint idx, output longint cnt);
    idx = 0; cnt = 0;
    if (s < 0 || c < 0) return 0;
    if (bm && ((s % 4) != 0 || (c % 4) != 0)) return 0;
    idx = bm ? s / 4 : s;
    cnt = bm ? c / 4 : c;
    if (idx >= FW) return 0;
    if (idx + cnt > FW) return 0;
    return 1;
  endfunction

  task automatic run_req(input bit bm, input int s, input int c, input bit inject);
    longint eidx, ecnt;
    bit ok;
    int words, n, t_sb, t_tr, t_ce, t_cef, t_trf, t_sbf, t_done, t_clk1;
    int hi_run, lo_run, bad_hi, bad_lo, bad_pwr, bad_busy, dones, seen_rise;
    logic p_sb, p_tr, p_ce, p_ck;
    ok = model(bm, longint'(s), longint'(c), eidx, ecnt);
    @(negedge clk);
    while (busy_o) @(negedge clk);
    req_i = 1'b1; req_bytes_i = bm; req_start_i = s; req_count_i = c;
    @(negedge clk);
    req_i = 1'b0;
    if (!ok) begin
      chk(done_o && err_o, "R5 reject pulse (R2/R3/R4)", {done_o, err_o}, 2'b11);
      chk(!busy_o && !stby_n && !ce, "R5 no macro activity", {busy_o, stby_n, ce}, 0);
      @(negedge clk);
      chk(!done_o && !err_o && !busy_o, "R5 single-cycle pulse", {done_o, err_o}, 0);
      return;
    end
    words = 0; t_sb = -1; t_tr = -1; t_ce = -1; t_cef = -1; t_trf = -1; t_sbf = -1;
    t_done = -1; t_clk1 = -1; hi_run = 0; lo_run = 0; bad_hi = 0; bad_lo = 0;
    bad_pwr = 0; bad_busy = 0; dones = 0; seen_rise = 0;
    p_sb = 0; p_tr = 0; p_ce = 0; p_ck = 0;
    for (n = 0; n < 20000; n++) begin
      if (inject && (n == 1 || n == 60)) begin
        req_i = 1'b1; req_bytes_i = 1'b0; req_start_i = 5; req_count_i = 1;
      end else req_i = 1'b0;
      if (stby_n && !p_sb) t_sb = n;
      if (trim && !p_tr) t_tr = n;
      if (ce && !p_ce) t_ce = n;
      if (!ce && p_ce) t_cef = n;
      if (!trim && p_tr) t_trf = n;
      if (!stby_n && p_sb) t_sbf = n;
      if (pclk && !(ce && trim && stby_n)) bad_pwr++;
      if (pclk && !p_ck) begin
        if (t_clk1 < 0) t_clk1 = n;
        if (seen_rise != 0 && lo_run < LO) bad_lo++;
        seen_rise = 1;
      end
      if (!pclk && p_ck && hi_run != HI) bad_hi++;
      hi_run = pclk ? hi_run + 1 : 0;
      lo_run = pclk ? 0 : lo_run + 1;
      if (word_valid_o) begin
        chk(int'(word_idx_o) == eidx + words, "R8 word index (R1)", word_idx_o, eidx + words);
        chk(word_data_o == otp_tb_pkg::fuse_val(int'(eidx) + words), "R8 word data",
            word_data_o, otp_tb_pkg::fuse_val(int'(eidx) + words));
        words++;
      end
      if (done_o) begin
        dones++;
        if (t_done < 0) t_done = n;
        chk(!err_o && !busy_o, "R9 done without error", {err_o, busy_o}, 0);
        break;
      end
      if (!busy_o) bad_busy++;
      p_sb = stby_n; p_tr = trim; p_ce = ce; p_ck = pclk;
      @(negedge clk);
    end
    req_i = 1'b0;
    chk(t_done >= 0, "R10 run completes", t_done, 1);
    chk(words == ecnt, "R8 word count (R11 when zero)", words, ecnt);
    chk(t_sb == 0 && t_tr == t_sb + 1 && t_ce == t_tr + 1, "R6 power-up order",
        {t_sb[7:0], t_tr[7:0], t_ce[7:0]}, 24'h000102);
    chk(t_clk1 < 0 || t_clk1 > t_ce, "R6 clock after enable", t_clk1, t_ce + 1);
    chk(t_trf == t_cef + 1 && t_sbf == t_trf + 1 && t_done == t_sbf + 1, "R9 power-down order",
        t_done - t_cef, 3);
    chk(bad_hi == 0 && bad_lo == 0 && bad_pwr == 0, "R7 clock phases", {bad_hi, bad_lo, bad_pwr}, 0);
    chk(bad_busy == 0, "R10 busy held", bad_busy, 0);
    if (inject) begin
      repeat (3) @(negedge clk);
      chk(!busy_o && !done_o, "R10 request while busy ignored", {busy_o, done_o}, 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy_o && !done_o && !err_o && !word_valid_o, "R10 reset idle",
        {busy_o, done_o, err_o, word_valid_o}, 0);
    chk(!stby_n && !trim && !ce && !pclk, "R6 reset pins low", {stby_n, trim, ce, pclk}, 0);
    run_req(0, 0, 3, 0);                 // R1 word mode
    run_req(1, 32'h400, 16, 0);          // R1 byte mode, idx 256..259
    run_req(0, FW - 2, 2, 0);            // R4 ends exactly at array end
    run_req(1, 4 * (FW - 1), 4, 0);      // R1 last word in bytes
    run_req(0, FW - 1, 2, 0);            // R4 overrun by one
    run_req(0, FW, 0, 0);                // R4 start at end
    run_req(1, 2, 4, 0);                 // R2 misaligned offset
    run_req(1, 8, 6, 0);                 // R2 misaligned size
    run_req(0, -1, 1, 0);                // R3 negative start
    run_req(0, 4, -4, 0);                // R3 negative count
    run_req(0, 10, 0, 0);                // R11 zero count
    run_req(0, 100, 3, 1);               // R10 requests while busy
    for (int k = 0; k < 30; k++) begin
      int ix, cn, s, c;
      bit bm;
      bm = 1'($urandom % 2);
      ix = int'($urandom % (FW + 4));
      cn = int'($urandom % 6);
      s = bm ? ix * 4 + ((($urandom % 8) == 0) ? 2 : 0) : ix;
      c = bm ? cn * 4 : cn;
      run_req(bm, s, c, 0);
    end
    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule